// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is the serial front end of a small register device. It watches a clock line and a data line that have already been filtered and sampled into the system clock domain. It answers to one 7-bit bus address, and it returns a single open-drain enable: a 1 pulls the data line low. The address is chosen at board level by two strap inputs. Each strap carries a 2-bit code for the level its pin is tied to (0 = supply, 1 = ground, 2 = clock line, 3 = data line). Together the two straps give sixteen addresses, from byte value 0x90 to byte value 0xAE.

A write transfer sends the address byte with bit 0 clear, then a register pointer byte, then any number of data bytes. Each data byte is written to the register port at the current pointer, and the pointer then steps forward by one. A read transfer sends the address byte with bit 0 set, usually after a repeated START. It streams bytes from the stored pointer for as long as the master acknowledges them. A STOP or a START on the bus abandons whatever byte is in progress.

Top module: `i2c_strap_slave`

## Requirements
- R1: The slave answers to the 7-bit address 0x48 + 4*code1 + code0, where `strap_a1` gives code1 and `strap_a0` gives code0. The 8-bit address byte therefore runs from 0x90 (both codes 0) to 0xAE (both codes 3). Bits 7:1 of the first byte after a START hold the address, and bit 0 gives the direction: 0 for write, 1 for read.
- R2: On the ninth clock of a matching address byte, the slave pulls the data line low. It does the same for the pointer byte and for every data byte written.
- R3: The slave never drives the data line for an address byte that does not match. It also ignores every byte after such an address until the next START, so no register write takes place.
- R4: In a write, the first byte after the address loads the register pointer. Each following byte, taken MSB first, produces exactly one single-cycle `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: The pointer steps forward by one, modulo 2^PTR_W, after each byte written and after each read byte that the master acknowledges.
- R6: A read returns the register at the stored pointer, MSB first. It then returns the following registers while the master keeps acknowledging.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and leaves it released until the next START.
- R8: A STOP or START anywhere in a transfer abandons the current byte, and a partly received data byte is never written. A START always begins a new address byte.
- R9: `sda_oe` is 0 out of reset, and it changes only in the cycle after a clock-line fall. It never changes while the clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Filtered, synchronous clock line |
| sda_i | input | 1 | Filtered, synchronous data line (wired level) |
| strap_a1 | input | 2 | Upper strap level code |
| strap_a0 | input | 2 | Lower strap level code |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | PTR_W | Register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
The bench builds the block with PTR_W = 8 and with the straps taken combinationally (REG_STRAP = 0). At these values a write that starts at pointer 0xFE wraps round to 0x00 within a few bytes, so the wrap path is exercised. The setting also lets the bench move through all sixteen strap codes between transfers with no settling delay.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_SUB, ST_ACK_SUB,
    ST_WDATA, ST_ACK_W, ST_RDATA, ST_RACK
  } i2cs_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } i2cs_evt_t;
endpackage

// File: rtl/i2cs_line_events.sv
module i2cs_line_events
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_i,
  input  logic      sda_i,
  output i2cs_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt.scl_rise = scl_i & ~scl_q;
    evt.scl_fall = ~scl_i & scl_q;
    evt.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt.stop     = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cs_strap_addr.sv
module i2cs_strap_addr #(
  parameter logic [6:0] ADDR_BASE = 7'h48,
  parameter bit         REG_STRAP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_a1,
  input  logic [1:0] strap_a0,
  output logic [6:0] own_addr
);
  logic [6:0] addr_c;

  // Upper strap moves the address in steps of four, lower strap in steps of one
  assign addr_c = ADDR_BASE + {3'b000, strap_a1, 2'b00} + {5'b00000, strap_a0};

  generate
    if (REG_STRAP) begin : g_reg
      logic [6:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= ADDR_BASE;
        else        addr_q <= addr_c;
      end
      assign own_addr = addr_q;
    end else begin : g_comb
      assign own_addr = addr_c;
    end
  endgenerate
endmodule

// File: rtl/i2cs_byte_fsm.sv
module i2cs_byte_fsm
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  i2cs_evt_t         evt,
  input  logic              sda_i,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  i2cs_state_e       st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n, tx_q, tx_n, wd_q, wd_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              oe_q, oe_n, ackon_q, ackon_n, rw_q, rw_n;
  logic              mack_q, mack_n, wr_q, wr_n;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {rx_q[BYTE_W-2:0], sda_i};

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; rx_n = rx_q; tx_n = tx_q; wd_n = wd_q;
    ptr_n = ptr_q; oe_n = oe_q; ackon_n = ackon_q; rw_n = rw_q;
    mack_n = mack_q; wr_n = 1'b0;
    if (evt.start) begin
      st_n = ST_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else if (evt.stop) begin
      st_n = ST_IDLE; oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (evt.scl_rise) begin
            rx_n  = byte_in;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              ackon_n = 1'b0;
              if (st_q == ST_ADDR) begin
                if (byte_in[BYTE_W-1:1] == own_addr) begin
                  rw_n = byte_in[0];
                  st_n = ST_ACK_ADDR;
                end else begin
                  st_n = ST_IDLE;
                end
              end else if (st_q == ST_SUB) begin
                ptr_n = PTR_W'(byte_in);
                st_n  = ST_ACK_SUB;
              end else begin
                wr_n = 1'b1;
                wd_n = byte_in;
                st_n = ST_ACK_W;
              end
            end
          end
        end
        ST_ACK_ADDR, ST_ACK_SUB, ST_ACK_W: begin
          if (evt.scl_fall) begin
            if (!ackon_q) begin
              ackon_n = 1'b1;
              oe_n    = 1'b1;
            end else begin
              oe_n  = 1'b0;
              cnt_n = '0;
              if (st_q == ST_ACK_ADDR && rw_q) begin
                tx_n = reg_rdata;
                oe_n = ~reg_rdata[BYTE_W-1];
                st_n = ST_RDATA;
              end else if (st_q == ST_ACK_ADDR) begin
                st_n = ST_SUB;
              end else begin
                if (st_q == ST_ACK_W) ptr_n = ptr_q + 1'b1;
                st_n = ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (evt.scl_rise) cnt_n = cnt_q + 1'b1;
          if (evt.scl_fall) begin
            if (cnt_q == ALL_BITS) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
              oe_n = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (evt.scl_rise) begin
            mack_n = ~sda_i;
            if (!sda_i) ptr_n = ptr_q + 1'b1;
          end
          if (evt.scl_fall) begin
            if (mack_q) begin
              tx_n  = reg_rdata;
              oe_n  = ~reg_rdata[BYTE_W-1];
              cnt_n = '0;
              st_n  = ST_RDATA;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; rx_q <= '0; tx_q <= '0; wd_q <= '0;
      ptr_q <= '0; oe_q <= 1'b0; ackon_q <= 1'b0; rw_q <= 1'b0;
      mack_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; rx_q <= rx_n; tx_q <= tx_n; wd_q <= wd_n;
      ptr_q <= ptr_n; oe_q <= oe_n; ackon_q <= ackon_n; rw_q <= rw_n;
      mack_q <= mack_n; wr_q <= wr_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wd_q;
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter int         PTR_W     = 8,
  parameter logic [6:0] ADDR_BASE = 7'h48,
  parameter bit         REG_STRAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_a1,
  input  logic [1:0]        strap_a0,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  i2cs_evt_t  evt;
  logic [6:0] own_addr;

  // Asynchronous assertion, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  i2cs_line_events u_evt (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
  );

  i2cs_strap_addr #(.ADDR_BASE(ADDR_BASE), .REG_STRAP(REG_STRAP)) u_addr (
    .clk(clk), .rst_n(rst_sn), .strap_a1(strap_a1), .strap_a0(strap_a0),
    .own_addr(own_addr)
  );

  i2cs_byte_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .evt(evt), .sda_i(sda_i), .own_addr(own_addr),
    .reg_rdata(reg_rdata), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic [1:0] strap_a1,
  input logic [1:0] strap_a0,
  input logic [6:0] own_addr,
  input logic       sda_oe,
  input logic       reg_wr
);
  logic p_scl, p_sda, stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_scl <= 1'b1;
      p_sda <= 1'b1;
    end else begin
      p_scl <= scl_i;
      p_sda <= sda_i;
    end
  end

  assign stop_seen = scl_i & p_scl & ~p_sda & sda_i;

  // R1: strap codes map onto the address byte 0x90 + 8*code1 + 2*code0
  a_r1_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(strap_a1) && $stable(strap_a0)) |=>
      ({own_addr, 1'b0} == 8'(8'h90 + 8'({strap_a1, 3'b000}) + 8'({strap_a0, 1'b0}))));

  // R4: a write strobe lasts a single cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R8: after a STOP the line is released and nothing is written
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!sda_oe && !reg_wr));

  // R9: the drive does not move while the clock line stays high
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_i && p_scl) |-> $stable(sda_oe));
endmodule

bind i2c_strap_slave i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .strap_a1(strap_a1), .strap_a0(strap_a0), .own_addr(own_addr),
  .sda_oe(sda_oe), .reg_wr(reg_wr)
);

// File: tb/tb_i2c_strap_slave.sv
`timescale 1ns/1ps
module tb_i2c_strap_slave;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [1:0] s1, s0;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire  sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] ptr_m;
  int wr_cnt = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_strap_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_a1(s1), .strap_a0(s0), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [7:0] addr_byte(input logic [1:0] a1, input logic [1:0] a0);
    return 8'h90 + 8'(a1) * 8'd8 + 8'(a0) * 8'd2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic i2c_bit(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); r = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) i2c_bit(d[i], r);
    i2c_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      i2c_bit(1'b1, r);
      d = {d[6:0], r};
    end
    i2c_bit(~mack, r);
  endtask

  // Write with expected-model update and ack checks (R2, R4, R5)
  task automatic do_write(input logic [7:0] sub, input int n);
    logic ack; logic [7:0] d; int w0;
    w0 = wr_cnt;
    i2c_start();
    send_byte(addr_byte(s1, s0), ack); check(ack, "R1 addr ack", ack, 1);
    send_byte(sub, ack);               check(ack, "R2 sub ack", ack, 1);
    ptr_m = sub;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);               check(ack, "R2 data ack", ack, 1);
      exp_mem[ptr_m] = d;
      ptr_m++;
    end
    i2c_stop();
    tick(2);
    check(wr_cnt - w0 == n, "R4 write strobes", wr_cnt - w0, n);
  endtask

  // Repeated-START read from sub, R6 / R5
  task automatic do_read(input logic [7:0] sub, input int n);
    logic ack; logic [7:0] d;
    i2c_start();
    send_byte(addr_byte(s1, s0), ack); check(ack, "R2 addr ack", ack, 1);
    send_byte(sub, ack);               check(ack, "R2 sub ack", ack, 1);
    ptr_m = sub;
    i2c_start();
    send_byte(addr_byte(s1, s0) | 8'h01, ack); check(ack, "R6 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d == exp_mem[ptr_m], "R6 R5 read data", d, exp_mem[ptr_m]);
      if (i != n - 1) ptr_m++;
    end
    i2c_stop();
  endtask

  initial begin
    logic ack, r; logic [7:0] d; int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    scl_m = 1; sda_m = 1; s1 = 0; s0 = 0; rst_n = 0;
    tick(4);
    check(sda_oe == 0, "R9 reset oe", sda_oe, 0);
    check(reg_wr == 0, "R4 reset wr", reg_wr, 0);
    rst_n = 1; tick(4);

    // R1 / R3: every strap combination, match and mismatch
    for (int a = 0; a < 16; a++) begin
      s1 = 2'(a >> 2); s0 = 2'(a); tick(2);
      i2c_start();
      send_byte(addr_byte(s1, s0), ack);
      check(ack, "R1 strap match", ack, 1);
      i2c_stop();
      i2c_start();
      send_byte(addr_byte(s1 ^ 2'b01, s0), ack);
      check(!ack, "R3 strap mismatch", ack, 0);
      i2c_stop();
    end

    // R5: pointer wrap across the top
    s1 = 2; s0 = 3; tick(2);
    do_write(8'hFE, 3);
    do_read(8'hFE, 3);

    // R3: bytes after a foreign address are ignored
    w0 = wr_cnt;
    i2c_start();
    send_byte(addr_byte(s1, s0) ^ 8'h02, ack); check(!ack, "R3 foreign addr", ack, 0);
    send_byte(8'h40, ack);                    check(!ack, "R3 foreign sub", ack, 0);
    send_byte(8'hC3, ack);                    check(!ack, "R3 foreign data", ack, 0);
    i2c_stop(); tick(2);
    check(wr_cnt == w0, "R3 no write", wr_cnt - w0, 0);
    do_read(8'h40, 1);

    // R7: after a master NACK the slave stays off the line
    i2c_start();
    send_byte(addr_byte(s1, s0) | 8'h01, ack);
    recv_byte(1'b0, d);
    for (int i = 0; i < 9; i++) begin
      i2c_bit(1'b1, r);
      check(r == 1'b1, "R7 released after nack", r, 1);
    end
    i2c_stop();

    // R8: STOP mid-byte drops the partial byte
    w0 = wr_cnt;
    i2c_start();
    send_byte(addr_byte(s1, s0), ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 4; i++) i2c_bit(1'b0, r);
    i2c_stop(); tick(2);
    check(wr_cnt == w0, "R8 stop abort", wr_cnt - w0, 0);
    // R8: START mid-byte, then read from the pointer set before it
    i2c_start();
    send_byte(addr_byte(s1, s0), ack);
    send_byte(8'h21, ack);
    for (int i = 0; i < 4; i++) i2c_bit(1'b1, r);
    i2c_start();
    send_byte(addr_byte(s1, s0) | 8'h01, ack);
    check(ack, "R8 restart addr", ack, 1);
    recv_byte(1'b0, d);
    check(d == exp_mem[8'h21], "R8 restart read", d, exp_mem[8'h21]);
    i2c_stop(); tick(2);
    check(wr_cnt == w0, "R8 start abort", wr_cnt - w0, 0);

    // Random mix of straps, pointers and lengths
    for (int t = 0; t < 40; t++) begin
      int n;
      logic [7:0] sub;
      s1 = 2'($urandom); s0 = 2'($urandom); tick(2);
      sub = 8'($urandom);
      n = 1 + int'($urandom % 4);
      do_write(sub, n);
      do_read(sub, n);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule